// File: doc/BRIEF.md
# Broadcast Scaled-Vector Register Writer

This block owns a small register file and, on a single command, runs a fixed sequence over it. It gathers a four-element vector X from four adjacent registers and a four-element vector Y from another four adjacent registers. It adds the Y elements into one scale value and multiplies each X element by that scale. The four products then go out as a burst of register writes. The burst fills consecutive destination registers with the product vector, repeated a power-of-two number of times.

A command carries three base indices (X, Y, destination), an 8-bit repeat code and a mode bit. In overwrite mode the destination's previous contents are discarded. In accumulate mode each product is added to the value already held in its destination register. The one exception is the first register of the burst, which is always overwritten. The arithmetic is two's-complement integer, 32 bits wide, and every sum and product keeps its low 32 bits. A test port loads and reads the register file while no command is running.

Top module: `bcast_scale_writer`

## Requirements
- R1: While reset is held and in the first cycle after it, `busy`, `done` and `err` are all 0.
- R2: Each result element k (k = 0..3) equals X[k] * (Y[0]+Y[1]+Y[2]+Y[3]), with every operation keeping the low 32 bits. X[k] is read from register `x_base`+k and Y[k] from register `y_base`+k.
- R3: The repeat count is 1 << `imm`[7:5], from 1 up to 32. Result element k of repetition r is written to register `d_base` + 4r + k.
- R4: With `accum` = 0, every written register receives the bare result element, whatever it held before.
- R5: With `accum` = 1, every written register except `d_base` receives its old contents plus the result element. Register `d_base` receives the bare result element.
- R6: If `start` arrives with `imm` > 160, `done` and `err` pulse together for one cycle on the next clock edge, `busy` stays 0, and no register changes.
- R7: For an accepted command with N = 4 * repeat count writes, `busy` is 1 from the edge that samples `start` until the burst ends. `done` is a one-cycle pulse that rises 10 + N edges after `start` is sampled, in the same edge at which `busy` falls.
- R8: All register indices (sources and destinations) wrap modulo the register-file depth.
- R9: All eight source values are read before the first destination write, so overlapping source and destination ranges behave as if the sources were captured at the start.
- R10: While `busy` is 1, a further `start` pulse and any test-port write are ignored. The running burst's results and timing are unchanged, and the test-port target keeps its value.
- R11: While idle, `tp_we` writes `tp_wdata` to register `tp_addr`. `tp_rdata` shows the contents of the register addressed by `tp_addr` one clock edge later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Command request, sampled while idle |
| accum | input | 1 | 0 = overwrite, 1 = accumulate |
| x_base | input | 8 | Index of the first X source register |
| y_base | input | 8 | Index of the first Y source register |
| d_base | input | 8 | Index of the first destination register |
| imm | input | 8 | Repeat code; bits 7:5 give the log2 of the repeat count |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | One-cycle rejection pulse, given together with `done` |
| tp_we | input | 1 | Test-port write enable |
| tp_addr | input | 8 | Test-port register index |
| tp_wdata | input | 32 | Test-port write data |
| tp_rdata | output | 32 | Test-port read data, one cycle latency |

## Verification
The assertions take the following for granted:
- The register-file depth is a power of two and at least four, so the write of one index and the prefetch of the next never target the same entry.
- `imm` and the base indices are stable in the cycle that `start` is sampled.

The stimulus keeps the test port idle while a command runs, except in the one scenario meant to show that a write there is blocked. It loads the whole file through the test port before the first command, so no source register is uninitialised. Every run is followed by a full read-back that is compared against a bench model of the file. That read-back shows both the intended writes and the absence of stray ones.

// File: rtl/bsw_pkg.sv
package bsw_pkg;
  // Number of elements in X, Y and the result vector.
  localparam int VEC_LEN  = 4;
  // Source registers gathered per command (X then Y).
  localparam int SRC_REGS = 2 * VEC_LEN;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_FETCH,
    ST_SUM,
    ST_WRITE
  } seq_state_t;
endpackage

// File: rtl/bsw_regfile.sv
module bsw_regfile #(
  parameter int DEPTH = 256,
  parameter int DW    = 32,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] ra_addr,
  output logic [DW-1:0] ra_data,
  input  logic [AW-1:0] rb_addr,
  output logic [DW-1:0] rb_data
);
  // One write port and two registered read ports, no reset on the array.
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    ra_data <= mem[ra_addr];
    rb_data <= mem[rb_addr];
  end
endmodule

// File: rtl/bsw_seq.sv
module bsw_seq
  import bsw_pkg::*;
#(
  parameter int AW      = 8,
  parameter int IMM_W   = 8,
  parameter int IMM_MAX = 160,
  parameter int REP_LSB = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          accum,
  input  logic [AW-1:0] x_base,
  input  logic [AW-1:0] y_base,
  input  logic [AW-1:0] d_base,
  input  logic [IMM_W-1:0] imm,
  output logic          busy,
  output logic          done,
  output logic          err,
  output logic [AW-1:0] raddr,
  output logic          cap_en,
  output logic [2:0]    cap_idx,
  output logic          mul_en,
  output logic          wr_en,
  output logic [AW-1:0] waddr,
  output logic [1:0]    sel,
  output logic          add_old
);
  localparam int MAX_SH = IMM_MAX >> REP_LSB;
  localparam int CW     = (MAX_SH + 3 > 4) ? MAX_SH + 3 : 4;

  seq_state_t    state;
  logic [CW-1:0] cnt;
  logic [CW-1:0] last_q;
  logic [AW-1:0] x_q, y_q, d_q;
  logic          acc_q;

  // Read address, capture and write controls follow the state and counter.
  always_comb begin
    raddr   = d_q;
    cap_en  = 1'b0;
    cap_idx = 3'(cnt - CW'(1));
    mul_en  = 1'b0;
    wr_en   = 1'b0;
    waddr   = d_q + AW'(cnt);
    sel     = cnt[1:0];
    add_old = 1'b0;
    case (state)
      ST_FETCH: begin
        if (cnt < CW'(VEC_LEN))        raddr = x_q + AW'(cnt);
        else if (cnt < CW'(SRC_REGS))  raddr = y_q + AW'(cnt - CW'(VEC_LEN));
        else                           raddr = d_q;
        cap_en = (cnt != '0);
      end
      ST_SUM: begin
        raddr  = d_q;
        mul_en = 1'b1;
      end
      ST_WRITE: begin
        // Prefetch the next destination while writing the current one.
        raddr   = d_q + AW'(cnt) + AW'(1);
        wr_en   = 1'b1;
        add_old = acc_q && (cnt != '0);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      cnt    <= '0;
      last_q <= '0;
      x_q    <= '0;
      y_q    <= '0;
      d_q    <= '0;
      acc_q  <= 1'b0;
      busy   <= 1'b0;
      done   <= 1'b0;
      err    <= 1'b0;
    end else begin
      done <= 1'b0;
      err  <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            if (imm > IMM_W'(IMM_MAX)) begin
              done <= 1'b1;
              err  <= 1'b1;
            end else begin
              x_q    <= x_base;
              y_q    <= y_base;
              d_q    <= d_base;
              acc_q  <= accum;
              last_q <= (CW'(VEC_LEN) << imm[IMM_W-1:REP_LSB]) - CW'(1);
              cnt    <= '0;
              busy   <= 1'b1;
              state  <= ST_FETCH;
            end
          end
        end
        ST_FETCH: begin
          if (cnt == CW'(SRC_REGS)) begin
            cnt   <= '0;
            state <= ST_SUM;
          end else begin
            cnt <= cnt + CW'(1);
          end
        end
        ST_SUM: state <= ST_WRITE;
        ST_WRITE: begin
          if (cnt == last_q) begin
            cnt   <= '0;
            busy  <= 1'b0;
            done  <= 1'b1;
            state <= ST_IDLE;
          end else begin
            cnt <= cnt + CW'(1);
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/bsw_datapath.sv
module bsw_datapath
  import bsw_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          cap_en,
  input  logic [2:0]    cap_idx,
  input  logic [DW-1:0] rd_data,
  input  logic          mul_en,
  input  logic [1:0]    sel,
  input  logic          add_old,
  output logic [DW-1:0] wdata
);
  logic [DW-1:0] src_q  [SRC_REGS];
  logic [DW-1:0] prod_q [VEC_LEN];
  logic [DW-1:0] ysum;

  always_ff @(posedge clk) begin
    if (cap_en) src_q[cap_idx] <= rd_data;
  end

  always_comb begin
    ysum = '0;
    for (int i = 0; i < VEC_LEN; i++) ysum = ysum + src_q[VEC_LEN + i];
  end

  for (genvar g = 0; g < VEC_LEN; g++) begin : g_mul
    always_ff @(posedge clk) begin
      if (mul_en) prod_q[g] <= src_q[g] * ysum;
    end
  end

  assign wdata = prod_q[sel] + (add_old ? rd_data : '0);
endmodule

// File: rtl/bcast_scale_writer.sv
module bcast_scale_writer #(
  parameter int DEPTH   = 256,
  parameter int DW      = 32,
  parameter int IMM_W   = 8,
  parameter int IMM_MAX = 160,
  localparam int AW     = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             accum,
  input  logic [AW-1:0]    x_base,
  input  logic [AW-1:0]    y_base,
  input  logic [AW-1:0]    d_base,
  input  logic [IMM_W-1:0] imm,
  output logic             busy,
  output logic             done,
  output logic             err,
  input  logic             tp_we,
  input  logic [AW-1:0]    tp_addr,
  input  logic [DW-1:0]    tp_wdata,
  output logic [DW-1:0]    tp_rdata
);
  logic [AW-1:0] seq_raddr, seq_waddr, rf_waddr;
  logic [DW-1:0] seq_rdata, seq_wdata, rf_wdata;
  logic          cap_en, mul_en, seq_we, add_old, rf_we;
  logic [2:0]    cap_idx;
  logic [1:0]    sel;

  bsw_seq #(.AW(AW), .IMM_W(IMM_W), .IMM_MAX(IMM_MAX), .REP_LSB(5)) u_seq (
    .clk(clk), .rst(rst), .start(start), .accum(accum),
    .x_base(x_base), .y_base(y_base), .d_base(d_base), .imm(imm),
    .busy(busy), .done(done), .err(err),
    .raddr(seq_raddr), .cap_en(cap_en), .cap_idx(cap_idx), .mul_en(mul_en),
    .wr_en(seq_we), .waddr(seq_waddr), .sel(sel), .add_old(add_old)
  );

  bsw_datapath #(.DW(DW)) u_dp (
    .clk(clk), .cap_en(cap_en), .cap_idx(cap_idx), .rd_data(seq_rdata),
    .mul_en(mul_en), .sel(sel), .add_old(add_old), .wdata(seq_wdata)
  );

  // The sequencer owns the write port while a command runs.
  assign rf_we    = seq_we | (tp_we & ~busy);
  assign rf_waddr = seq_we ? seq_waddr : tp_addr;
  assign rf_wdata = seq_we ? seq_wdata : tp_wdata;

  bsw_regfile #(.DEPTH(DEPTH), .DW(DW), .AW(AW)) u_rf (
    .clk(clk), .we(rf_we), .waddr(rf_waddr), .wdata(rf_wdata),
    .ra_addr(seq_raddr), .ra_data(seq_rdata),
    .rb_addr(tp_addr), .rb_data(tp_rdata)
  );
endmodule

// File: rtl/bsw_checker.sv
module bsw_checker #(
  parameter int IMM_W   = 8,
  parameter int IMM_MAX = 160
) (
  input logic             clk,
  input logic             rst,
  input logic             start,
  input logic [IMM_W-1:0] imm,
  input logic             busy,
  input logic             done,
  input logic             err,
  input logic             tp_we,
  input logic             seq_we,
  input logic             rf_we
);
  a_r7_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r7_busy_done_apart: assert property (@(posedge clk) disable iff (rst)
    !(busy && done));

  a_r7_busy_from_start: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> ($past(start) && ($past(imm) <= IMM_W'(IMM_MAX))));

  a_r7_done_ends_busy: assert property (@(posedge clk) disable iff (rst)
    (done && !err) |-> $past(busy));

  a_r6_err_cause: assert property (@(posedge clk) disable iff (rst)
    err |-> (done && !busy && $past(start) && ($past(imm) > IMM_W'(IMM_MAX))));

  a_r10_seq_write_busy: assert property (@(posedge clk) disable iff (rst)
    seq_we |-> busy);

  a_r10_tp_blocked: assert property (@(posedge clk) disable iff (rst)
    (busy && tp_we && !seq_we) |-> !rf_we);
endmodule

bind bcast_scale_writer bsw_checker #(.IMM_W(IMM_W), .IMM_MAX(IMM_MAX)) u_chk (
  .clk(clk), .rst(rst), .start(start), .imm(imm), .busy(busy), .done(done),
  .err(err), .tp_we(tp_we), .seq_we(seq_we), .rf_we(rf_we)
);

// File: tb/bcast_scale_writer_bench.sv
module bcast_scale_writer_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 256;

  logic        clk, rst, start, accum, tp_we;
  logic [7:0]  x_base, y_base, d_base, imm, tp_addr;
  logic [31:0] tp_wdata, tp_rdata;
  logic        busy, done, err;

  bcast_scale_writer u_bcast_scale_writer (
    .clk(clk), .rst(rst), .start(start), .accum(accum),
    .x_base(x_base), .y_base(y_base), .d_base(d_base), .imm(imm),
    .busy(busy), .done(done), .err(err),
    .tp_we(tp_we), .tp_addr(tp_addr), .tp_wdata(tp_wdata), .tp_rdata(tp_rdata)
  );

  typedef struct {
    logic [7:0]  a;
    logic [31:0] d;
    string       tag;
  } exp_t;

  exp_t        sb_q [$];
  logic [31:0] model [DEPTH];
  int          n_cmp = 0;
  int          n_bad = 0;
  bit          reported = 0;
  logic        rd_pend = 0;
  logic        rd_pend_q = 0;

  initial clk = 0;
  always #(CLK_PERIOD/2) clk = ~clk;

  always_ff @(posedge clk) rd_pend_q <= rd_pend;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, expv);
    end
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    end
  endtask

  // Monitor: one registered read result per cycle after a pending request.
  initial begin
    forever begin
      @(negedge clk);
      if (rd_pend_q) begin
        if (sb_q.size() == 0) begin
          check(0, "R11 scoreboard underflow", tp_rdata, 32'h0);
        end else begin
          exp_t e;
          e = sb_q.pop_front();
          check(tp_rdata === e.d, $sformatf("%s addr %0d", e.tag, e.a), tp_rdata, e.d);
        end
      end
    end
  end

  task automatic tp_write(input int a, input logic [31:0] d);
    @(posedge clk); #1;
    tp_we = 1; tp_addr = 8'(a); tp_wdata = d;
    model[a % DEPTH] = d;
    @(posedge clk); #1;
    tp_we = 0;
  endtask

  task automatic read_all(input string tag);
    for (int a = 0; a < DEPTH; a++) begin
      @(posedge clk); #1;
      tp_addr = 8'(a);
      rd_pend = 1;
      sb_q.push_back('{8'(a), model[a], tag});
    end
    @(posedge clk); #1;
    rd_pend = 0;
    @(posedge clk); #1;
  endtask

  // Issue one command, predict its effect on the model, check handshake timing.
  task automatic run_cmd(input int xb, input int yb, input int db, input int im,
                         input bit acc, input bit noise, input string tag);
    logic [31:0] xs [4];
    logic [31:0] ysum, res [4];
    int nw, k;
    for (int i = 0; i < 4; i++) xs[i] = model[(xb + i) % DEPTH];
    ysum = 0;
    for (int i = 0; i < 4; i++) ysum = ysum + model[(yb + i) % DEPTH];
    for (int i = 0; i < 4; i++) res[i] = xs[i] * ysum;
    nw = (im > 160) ? 0 : (4 << (im >> 5));
    for (int w = 0; w < nw; w++) begin
      int a;
      a = (db + w) % DEPTH;
      model[a] = res[w % 4] + ((acc && w != 0) ? model[a] : 32'h0);
    end

    @(posedge clk); #1;
    x_base = 8'(xb); y_base = 8'(yb); d_base = 8'(db); imm = 8'(im); accum = acc;
    start = 1;
    @(posedge clk); #1;
    start = 0;
    if (im > 160) begin
      check(done && err && !busy, {tag, " R6 reject pulse"}, {29'h0, busy, done, err}, 32'h3);
      @(posedge clk); #1;
      check(!done && !err && !busy, {tag, " R6 pulse ends"}, {29'h0, busy, done, err}, 32'h0);
    end else begin
      check(busy && !done, {tag, " R7 busy after start"}, {30'h0, busy, done}, 32'h2);
      k = 0;
      if (noise) begin
        @(posedge clk); #1;
        start = 1; x_base = 8'(db); y_base = 8'(db); d_base = 8'(xb); imm = 8'd160; accum = ~acc;
        tp_we = 1; tp_addr = 8'(xb); tp_wdata = 32'hDEAD_BEEF;
        @(posedge clk); #1;
        start = 0; tp_we = 0;
        k = 2;
      end
      repeat (9 + nw - k) @(posedge clk);
      #1;
      check(busy && !done, {tag, " R7 busy before end"}, {30'h0, busy, done}, 32'h2);
      @(posedge clk); #1;
      check(!busy && done && !err, {tag, " R7 done pulse"}, {29'h0, busy, done, err}, 32'h2);
      @(posedge clk); #1;
      check(!done && !busy, {tag, " R7 done single"}, {30'h0, busy, done}, 32'h0);
    end
    read_all(tag);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
    $finish;
  end

  initial begin
    rst = 1; start = 0; accum = 0; tp_we = 0;
    x_base = 0; y_base = 0; d_base = 0; imm = 0; tp_addr = 0; tp_wdata = 0;
    repeat (3) @(posedge clk);
    #1;
    check(!busy && !done && !err, "R1 reset held", {29'h0, busy, done, err}, 32'h0);
    rst = 0;
    @(posedge clk); #1;
    check(!busy && !done && !err, "R1 after reset", {29'h0, busy, done, err}, 32'h0);

    // R11: load the whole file, then read it back.
    for (int a = 0; a < DEPTH; a++) tp_write(a, 32'(a * 37) - 32'd4000);
    tp_write(20, 32'h4000_0001);
    tp_write(21, 32'h7FFF_FFF3);
    tp_write(22, 32'hFFFF_FF00);
    tp_write(23, 32'h0000_0123);
    tp_write(11, 32'h8000_0005);
    read_all("R11 load");

    run_cmd(10, 20, 40, 0, 0, 0, "R2 R4 single overwrite");
    run_cmd(10, 20, 40, 0, 0, 0, "R4 repeat overwrite");
    run_cmd(1, 5, 60, 31, 0, 0, "R3 code 31");
    run_cmd(2, 6, 80, 32, 0, 0, "R3 code 32");
    run_cmd(3, 7, 100, 64, 1, 0, "R5 accumulate");
    run_cmd(0, 4, 120, 160, 0, 0, "R3 max repeat");
    run_cmd(0, 4, 120, 161, 0, 0, "R6 just above");
    run_cmd(0, 4, 0, 255, 1, 0, "R6 far above");
    run_cmd(50, 52, 50, 32, 1, 0, "R9 overlap");
    run_cmd(254, 2, 254, 32, 0, 0, "R8 wrap");
    run_cmd(30, 40, 250, 64, 1, 0, "R8 R5 wrap accumulate");
    run_cmd(200, 210, 220, 32, 0, 1, "R10 ignored while busy");

    report();
    $finish;
  end
endmodule